// File: doc/BRIEF.md
# Extension Instruction Handle Dispatcher

This block sits beside a processor's decode stage and manages handles for a family of overloadable extension instructions. An open request names an interface by a 20-bit identifier. The block looks that identifier up in a small registry fixed at elaboration and claims a free slot in its handle table. The slot records which interface was opened and which address space opened it. Close requests and the eight ctl requests carry the handle in rs1. The block checks the handle against the table and against the caller's address space. It then either forwards a routed request to an external device port or answers at once with an exception code.

Each registry entry holds the interface identifier, a 12-bit device number on the hart, an 8-bit mask of the ctl numbers the interface implements, and a flag that says whether the interface has a shutdown routine. A foreign-address-space handle is reported exactly like an empty one, so a caller learns nothing about handles that belong to other address spaces. The device semantics and any per-handle cookie state stay in the devices. The block only passes the slot index along so that a device can find its own state.

The controller has four states. IDLE accepts a request and decides the outcome in the same cycle. DEV_REQ holds a routed request until the device takes it. DEV_WAIT waits for the device result. RESP holds the response until it is taken. The transitions are:

- IDLE→DEV_REQ on an accepted request that needs the device.
- IDLE→RESP on any other accepted request.
- DEV_REQ→DEV_WAIT on `dev_ready`.
- DEV_WAIT→RESP on `dev_rsp_valid`.
- RESP→IDLE on `rsp_ready`.

Top module: `ext_handle_dispatch`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `dev_valid` are 0, and every handle slot is empty.
- R2: `req_op` encodes 0 = open, 1 = close, 2 = ctl and 3 = reserved. An open takes the identifier from `req_rs1[19:0]`. If no registry entry matches, the open answers exception code 1 (unrecognised) and allocates no slot.
- R3: A successful open claims the lowest-numbered empty slot. It records the interface and `req_asid`, and answers exception 0 with data = slot index shifted left by 12.
- R4: An open of a registered identifier while every slot is in use answers exception code 4 (no free handle).
- R5: For close and ctl requests, `req_rs1[11:0]` is payload and is ignored for the lookup. The slot index is `req_rs1[12 +: log2(NSLOT)]`.
- R6: A ctl request that names an empty slot answers exception code 2 (unknown interface). So does a ctl request whose rs1 has any bit set above the slot field.
- R7: A ctl request on a slot owned by a different `req_asid` answers exception code 2, the same as an empty slot.
- R8: A ctl request on an owned slot whose interface mask lacks bit `req_ctl` answers exception code 3 (invalid instruction) and issues no device request.
- R9: A ctl request on an owned slot whose mask allows it issues exactly one device request. The request carries `dev_num` = the interface's device number, `dev_fn` = `req_ctl`, and rs1/rs2 unchanged. The response is exception 0 with data = `dev_result`.
- R10: A close on an empty or foreign slot answers exception 0 with data all ones and issues no device request.
- R11: A close on an owned slot whose interface has a shutdown issues one device request with `dev_fn` = 8 and returns `dev_result` unchanged. The slot is freed only if that result is 0.
- R12: A close on an owned slot whose interface has no shutdown frees the slot and answers exception 0, data 0, with no device request.
- R13: Only one request is in flight at a time: `req_ready` is low from acceptance until the response is taken. A pending response and a pending device request hold their values until taken.
- R14: A request with `req_op` = 3 answers exception code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_op | input | 2 | 0 open, 1 close, 2 ctl, 3 reserved |
| req_ctl | input | 3 | Ctl number for ctl requests |
| req_rs1 | input | XLEN | Identifier (open) or handle plus payload |
| req_rs2 | input | XLEN | Second operand, forwarded to the device |
| req_asid | input | ASID_W | Caller's address-space ID |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_exc | output | 3 | 0 none, 1 unrecognised, 2 unknown interface, 3 invalid instruction, 4 no free handle |
| rsp_data | output | XLEN | Result word |
| dev_valid | output | 1 | Routed device request present |
| dev_ready | input | 1 | Device takes the request |
| dev_num | output | 12 | Device number on the hart |
| dev_fn | output | 4 | 0..7 ctl number, 8 shutdown |
| dev_slot | output | log2(NSLOT) | Handle slot, so the device can find its state |
| dev_rs1 | output | XLEN | rs1 as received, payload included |
| dev_rs2 | output | XLEN | rs2 as received |
| dev_rsp_valid | input | 1 | Device result present |
| dev_result | input | XLEN | Device result word |

## Verification
The bench aims at the corners where one check can mask another:

- **Foreign-space handles.** A design that compared only the valid bit would run the foreign handle on the device instead of answering code 2.
- **Payload bits in rs1.** A lookup that kept the low 12 bits would hit the wrong slot or none at all.
- **A handle above the table range.** A truncated index would alias it onto slot 0.
- **A ctl number missing from the mask.** A missing mask test would send an unimplemented function to the device.
- **Close with a non-zero shutdown result.** A design that freed the slot regardless would fail the next ctl on that handle.
- **A rejected open followed by a good one.** This shows that nothing leaked out of the table.
- **A full table.** The bench fills it and checks that the next open gets code 4.

Random mixes of two address spaces, stalls on the device port and held responses then check that decisions and data survive back-pressure.

// File: rtl/ehd_pkg.sv
package ehd_pkg;
    localparam int ID_W  = 20;
    localparam int DEV_W = 12;
    localparam int NCTL  = 8;
    localparam int PAY_W = 12;
    localparam logic [3:0] FN_SHUT = 4'd8;

    typedef enum logic [1:0] {
        OP_OPEN  = 2'd0,
        OP_CLOSE = 2'd1,
        OP_CTL   = 2'd2,
        OP_RSVD  = 2'd3
    } ehd_op_e;

    typedef enum logic [2:0] {
        EXC_NONE    = 3'd0,
        EXC_UNRECOG = 3'd1,
        EXC_UNKNOWN = 3'd2,
        EXC_ILLEGAL = 3'd3,
        EXC_NOSLOT  = 3'd4
    } ehd_exc_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_DEV_REQ,
        S_DEV_WAIT,
        S_RESP
    } ehd_state_e;
endpackage

// File: rtl/ehd_registry.sv
module ehd_registry import ehd_pkg::*; #(
    parameter int NIF = 4,
    parameter logic [NIF*ID_W-1:0]  IF_IDS  = '0,
    parameter logic [NIF*DEV_W-1:0] IF_DEV  = '0,
    parameter logic [NIF*NCTL-1:0]  IF_MASK = '0,
    parameter logic [NIF-1:0]       IF_SHUT = '0,
    localparam int IFX_W = (NIF > 1) ? $clog2(NIF) : 1
) (
    input  logic [ID_W-1:0]  q_id,
    output logic             q_hit,
    output logic [IFX_W-1:0] q_ifx,
    input  logic [IFX_W-1:0] s_ifx,
    output logic [DEV_W-1:0] s_dev,
    output logic [NCTL-1:0]  s_mask,
    output logic             s_shut
);
    // Identifier search: lowest matching entry wins
    always_comb begin
        q_hit = 1'b0;
        q_ifx = '0;
        for (int i = NIF - 1; i >= 0; i--) begin
            if (IF_IDS[i*ID_W +: ID_W] == q_id) begin
                q_hit = 1'b1;
                q_ifx = IFX_W'(i);
            end
        end
    end

    // Attribute fetch by entry index
    always_comb begin
        s_dev  = '0;
        s_mask = '0;
        s_shut = 1'b0;
        for (int i = 0; i < NIF; i++) begin
            if (s_ifx == IFX_W'(i)) begin
                s_dev  = IF_DEV[i*DEV_W +: DEV_W];
                s_mask = IF_MASK[i*NCTL +: NCTL];
                s_shut = IF_SHUT[i];
            end
        end
    end
endmodule

// File: rtl/ehd_slot_table.sv
module ehd_slot_table #(
    parameter int NSLOT  = 16,
    parameter int IFX_W  = 2,
    parameter int ASID_W = 8,
    localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [IFX_W-1:0]  alloc_ifx,
    input  logic [ASID_W-1:0] alloc_asid,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [IFX_W-1:0]  rd_ifx,
    output logic [ASID_W-1:0] rd_asid,
    output logic              free_any,
    output logic [IDX_W-1:0]  free_idx
);
    logic [NSLOT-1:0]  vld_q;
    logic [IFX_W-1:0]  ifx_q  [NSLOT];
    logic [ASID_W-1:0] asid_q [NSLOT];

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (!vld_q[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        rd_valid = 1'b0;
        rd_ifx   = '0;
        rd_asid  = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_valid = vld_q[i];
                rd_ifx   = ifx_q[i];
                rd_asid  = asid_q[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            for (int i = 0; i < NSLOT; i++) begin
                if (alloc_en && free_idx == IDX_W'(i)) begin
                    vld_q[i] <= 1'b1;
                end else if (clr_en && clr_idx == IDX_W'(i)) begin
                    vld_q[i] <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NSLOT; i++) begin
            if (alloc_en && free_idx == IDX_W'(i)) begin
                ifx_q[i]  <= alloc_ifx;
                asid_q[i] <= alloc_asid;
            end
        end
    end
endmodule

// File: rtl/ext_handle_dispatch.sv
module ext_handle_dispatch import ehd_pkg::*; #(
    parameter int NSLOT  = 16,
    parameter int NIF    = 4,
    parameter int ASID_W = 8,
    parameter int XLEN   = 32,
    parameter logic [NIF*ID_W-1:0]  IF_IDS  = {20'h00001, 20'hFFFFF, 20'h01234, 20'h0ABCD},
    parameter logic [NIF*DEV_W-1:0] IF_DEV  = {12'h003, 12'h7FF, 12'h020, 12'h010},
    parameter logic [NIF*NCTL-1:0]  IF_MASK = {8'h80, 8'hFF, 8'h01, 8'h03},
    parameter logic [NIF-1:0]       IF_SHUT = 4'b0011,
    localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int IFX_W = (NIF > 1) ? $clog2(NIF) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [2:0]        req_ctl,
    input  logic [XLEN-1:0]   req_rs1,
    input  logic [XLEN-1:0]   req_rs2,
    input  logic [ASID_W-1:0] req_asid,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [2:0]        rsp_exc,
    output logic [XLEN-1:0]   rsp_data,
    output logic              dev_valid,
    input  logic              dev_ready,
    output logic [DEV_W-1:0]  dev_num,
    output logic [3:0]        dev_fn,
    output logic [IDX_W-1:0]  dev_slot,
    output logic [XLEN-1:0]   dev_rs1,
    output logic [XLEN-1:0]   dev_rs2,
    input  logic              dev_rsp_valid,
    input  logic [XLEN-1:0]   dev_result
);
    ehd_state_e state_q, state_d;

    // Registry and table wiring
    logic             q_hit;
    logic [IFX_W-1:0] q_ifx;
    logic [DEV_W-1:0] s_dev;
    logic [NCTL-1:0]  s_mask;
    logic             s_shut;
    logic              rd_valid, free_any;
    logic [IFX_W-1:0]  rd_ifx;
    logic [ASID_W-1:0] rd_asid;
    logic [IDX_W-1:0]  free_idx, slot_idx, clr_idx;
    logic              alloc_en, clr_en;

    // Decision of the current request
    logic             hi_zero, owned, take;
    ehd_exc_e         dec_exc;
    logic [XLEN-1:0]  dec_data;
    logic             dec_dev, dec_alloc, dec_clr;
    logic [3:0]       dec_fn;

    // Captured request and response
    logic [DEV_W-1:0] dev_num_q;
    logic [3:0]       dev_fn_q;
    logic [IDX_W-1:0] slot_q;
    logic [XLEN-1:0]  rs1_q, rs2_q, rsp_data_q;
    ehd_exc_e         rsp_exc_q;

    ehd_registry #(
        .NIF(NIF), .IF_IDS(IF_IDS), .IF_DEV(IF_DEV),
        .IF_MASK(IF_MASK), .IF_SHUT(IF_SHUT)
    ) u_registry (
        .q_id  (req_rs1[ID_W-1:0]),
        .q_hit (q_hit),
        .q_ifx (q_ifx),
        .s_ifx (rd_ifx),
        .s_dev (s_dev),
        .s_mask(s_mask),
        .s_shut(s_shut)
    );

    ehd_slot_table #(
        .NSLOT(NSLOT), .IFX_W(IFX_W), .ASID_W(ASID_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (alloc_en),
        .alloc_ifx (q_ifx),
        .alloc_asid(req_asid),
        .clr_en    (clr_en),
        .clr_idx   (clr_idx),
        .rd_idx    (slot_idx),
        .rd_valid  (rd_valid),
        .rd_ifx    (rd_ifx),
        .rd_asid   (rd_asid),
        .free_any  (free_any),
        .free_idx  (free_idx)
    );

    assign slot_idx = req_rs1[PAY_W +: IDX_W];
    assign hi_zero  = ~|(req_rs1 >> (PAY_W + IDX_W));
    assign owned    = rd_valid && hi_zero && (rd_asid == req_asid);
    assign take     = (state_q == S_IDLE) && req_valid;

    always_comb begin
        dec_exc   = EXC_NONE;
        dec_data  = '0;
        dec_dev   = 1'b0;
        dec_fn    = '0;
        dec_alloc = 1'b0;
        dec_clr   = 1'b0;
        unique case (ehd_op_e'(req_op))
            OP_OPEN: begin
                if (!q_hit) begin
                    dec_exc = EXC_UNRECOG;
                end else if (!free_any) begin
                    dec_exc = EXC_NOSLOT;
                end else begin
                    dec_alloc = 1'b1;
                    dec_data  = XLEN'(free_idx) << PAY_W;
                end
            end
            OP_CLOSE: begin
                if (!owned) begin
                    dec_data = '1;
                end else if (s_shut) begin
                    dec_dev = 1'b1;
                    dec_fn  = FN_SHUT;
                end else begin
                    dec_clr = 1'b1;
                end
            end
            OP_CTL: begin
                if (!owned) begin
                    dec_exc = EXC_UNKNOWN;
                end else if (!s_mask[req_ctl]) begin
                    dec_exc = EXC_ILLEGAL;
                end else begin
                    dec_dev = 1'b1;
                    dec_fn  = {1'b0, req_ctl};
                end
            end
            OP_RSVD: dec_exc = EXC_ILLEGAL;
        endcase
    end

    assign alloc_en = take && dec_alloc;
    assign clr_en   = (take && dec_clr) ||
                      (state_q == S_DEV_WAIT && dev_rsp_valid &&
                       dev_fn_q == FN_SHUT && dev_result == '0);
    assign clr_idx  = (state_q == S_IDLE) ? slot_idx : slot_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (req_valid)     state_d = dec_dev ? S_DEV_REQ : S_RESP;
            S_DEV_REQ:  if (dev_ready)     state_d = S_DEV_WAIT;
            S_DEV_WAIT: if (dev_rsp_valid) state_d = S_RESP;
            S_RESP:     if (rsp_ready)     state_d = S_IDLE;
        endcase
    end

    // Captured datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_exc_q  <= EXC_NONE;
            rsp_data_q <= '0;
            dev_num_q  <= '0;
            dev_fn_q   <= '0;
            slot_q     <= '0;
            rs1_q      <= '0;
            rs2_q      <= '0;
        end else if (take) begin
            rsp_exc_q  <= dec_exc;
            rsp_data_q <= dec_data;
            dev_num_q  <= s_dev;
            dev_fn_q   <= dec_fn;
            slot_q     <= slot_idx;
            rs1_q      <= req_rs1;
            rs2_q      <= req_rs2;
        end else if (state_q == S_DEV_WAIT && dev_rsp_valid) begin
            rsp_data_q <= dev_result;
        end
    end

    // Outputs
    always_comb begin
        req_ready = (state_q == S_IDLE);
        dev_valid = (state_q == S_DEV_REQ);
        rsp_valid = (state_q == S_RESP);
        rsp_exc   = rsp_exc_q;
        rsp_data  = rsp_data_q;
        dev_num   = dev_num_q;
        dev_fn    = dev_fn_q;
        dev_slot  = slot_q;
        dev_rs1   = rs1_q;
        dev_rs2   = rs2_q;
    end
endmodule

// File: rtl/ehd_checker.sv
module ehd_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [2:0]      rsp_exc,
    input logic [XLEN-1:0] rsp_data,
    input logic            dev_valid,
    input logic            dev_ready,
    input logic [11:0]     dev_num,
    input logic [3:0]      dev_fn,
    input logic            dev_rsp_valid
);
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (req_ready && !rsp_valid && !dev_valid));

    a_r13_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r13_rsp_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_exc)));

    a_r9_dev_held: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_valid && !dev_ready) |=> (dev_valid && $stable(dev_num) && $stable(dev_fn)));

    a_r9_rsp_after_result: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_valid && dev_ready) |=> !rsp_valid);

    a_r11_fn_range: assert property (@(posedge clk) disable iff (!rst_n)
        dev_valid |-> (dev_fn <= 4'd8));

    a_r14_exc_code: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_exc <= 3'd4));

    a_r9_no_stray_result: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rsp_valid |-> !dev_valid);
endmodule

bind ext_handle_dispatch ehd_checker #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_exc(rsp_exc),
    .rsp_data(rsp_data), .dev_valid(dev_valid), .dev_ready(dev_ready),
    .dev_num(dev_num), .dev_fn(dev_fn), .dev_rsp_valid(dev_rsp_valid)
);

// File: tb/ext_handle_dispatch_tb.sv
module ext_handle_dispatch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = '0;
    logic [2:0]  req_ctl = '0;
    logic [31:0] req_rs1 = '0, req_rs2 = '0;
    logic [7:0]  req_asid = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [2:0]  rsp_exc;
    logic [31:0] rsp_data;
    logic        dev_valid;
    logic        dev_ready = 1'b1;
    logic [11:0] dev_num;
    logic [3:0]  dev_fn;
    logic [3:0]  dev_slot;
    logic [31:0] dev_rs1, dev_rs2;
    logic        dev_rsp_valid = 1'b0;
    logic [31:0] dev_result = '0;

    int n_cmp = 0, n_bad = 0, dev_cnt = 0;
    logic [11:0] last_num;
    logic [3:0]  last_fn;
    logic [31:0] last_rs1, last_rs2;
    logic [31:0] shut_ret = '0;

    // Reference model state
    bit   m_vld [16];
    int   m_ifx [16];
    logic [7:0] m_asid [16];

    always #2 clk = ~clk;

    ext_handle_dispatch u_dut (.*);

    function automatic int reg_find(logic [19:0] id);
        case (id)
            20'h0ABCD: return 0;
            20'h01234: return 1;
            20'hFFFFF: return 2;
            20'h00001: return 3;
            default:   return -1;
        endcase
    endfunction
    function automatic logic [11:0] reg_dev(int i);
        logic [11:0] t [4] = '{12'h010, 12'h020, 12'h7FF, 12'h003};
        return t[i];
    endfunction
    function automatic logic [7:0] reg_mask(int i);
        logic [7:0] t [4] = '{8'h03, 8'h01, 8'hFF, 8'h80};
        return t[i];
    endfunction
    function automatic bit reg_shut(int i);
        return (i < 2);
    endfunction
    function automatic logic [31:0] dres(logic [11:0] n, logic [3:0] f, logic [31:0] a, logic [31:0] b);
        return b + {n, f, 16'h5A5A} + (a >> 3);
    endfunction

    // Behavioural device
    always @(posedge clk) begin
        dev_rsp_valid <= 1'b0;
        if (rst_n && dev_valid && dev_ready) begin
            dev_rsp_valid <= 1'b1;
            dev_result    <= (dev_fn == 4'd8) ? shut_ret : dres(dev_num, dev_fn, dev_rs1, dev_rs2);
            last_num <= dev_num; last_fn <= dev_fn;
            last_rs1 <= dev_rs1; last_rs2 <= dev_rs2;
            dev_cnt  <= dev_cnt + 1;
        end
    end
    always @(negedge clk) dev_ready <= ($urandom_range(0, 3) != 0);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic run(input logic [1:0] op, input logic [2:0] ctl, input logic [31:0] rs1,
                       input logic [31:0] rs2, input logic [7:0] asid, input int hold, input string tag);
        logic [2:0]  e_exc = 3'd0;
        logic [31:0] e_data = '0;
        bit          e_dev = 0;
        logic [3:0]  e_fn = '0;
        logic [11:0] e_num = '0;
        int          idx = int'(rs1[15:12]);
        bit          own = (rs1[31:16] == 0) && m_vld[idx] && (m_asid[idx] == asid);
        int          c0;
        logic [31:0] d0;
        if (op == 2'd0) begin
            int f = reg_find(rs1[19:0]);
            int s = -1;
            for (int i = 15; i >= 0; i--) if (!m_vld[i]) s = i;
            if (f < 0) e_exc = 3'd1;
            else if (s < 0) e_exc = 3'd4;
            else begin
                e_data = 32'(s) << 12;
                m_vld[s] = 1; m_ifx[s] = f; m_asid[s] = asid;
            end
        end else if (op == 2'd1) begin
            if (!own) e_data = '1;
            else if (reg_shut(m_ifx[idx])) begin
                e_dev = 1; e_fn = 4'd8; e_num = reg_dev(m_ifx[idx]); e_data = shut_ret;
                if (shut_ret == 0) m_vld[idx] = 0;
            end else m_vld[idx] = 0;
        end else if (op == 2'd2) begin
            if (!own) e_exc = 3'd2;
            else if (!reg_mask(m_ifx[idx])[ctl]) e_exc = 3'd3;
            else begin
                e_dev = 1; e_fn = {1'b0, ctl}; e_num = reg_dev(m_ifx[idx]);
                e_data = dres(e_num, e_fn, rs1, rs2);
            end
        end else e_exc = 3'd3;

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        c0 = dev_cnt;
        req_valid = 1; req_op = op; req_ctl = ctl; req_rs1 = rs1; req_rs2 = rs2; req_asid = asid;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        while (!rsp_valid) @(negedge clk);
        d0 = rsp_data;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(rsp_valid && !req_ready && rsp_data == d0, {tag, " R13 held response"}, rsp_data, d0);
        end
        chk(rsp_exc == e_exc, {tag, " exc"}, 32'(rsp_exc), 32'(e_exc));
        chk(rsp_data == e_data, {tag, " data"}, rsp_data, e_data);
        chk((dev_cnt - c0) == int'(e_dev), {tag, " device requests"}, 32'(dev_cnt - c0), 32'(e_dev));
        if (e_dev) begin
            chk(last_num == e_num && last_fn == e_fn, {tag, " R9 route num/fn"},
                {16'h0, last_num, last_fn}, {16'h0, e_num, e_fn});
            chk(last_rs1 == rs1 && last_rs2 == rs2, {tag, " R9 operands"}, last_rs1, rs1);
        end
        rsp_ready = 1;
        @(negedge clk);
        rsp_ready = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int unsigned seed = 32'h1D2C3B4A;
        void'($urandom(seed));
        for (int i = 0; i < 16; i++) begin m_vld[i] = 0; m_ifx[i] = 0; m_asid[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !dev_valid, "R1 reset state",
            {29'h0, req_ready, rsp_valid, dev_valid}, 32'h4);

        run(2'd0, 3'd0, 32'h0005_5555, 0, 8'd1, 0, "R2 unknown id");
        run(2'd0, 3'd0, 32'hABC0_ABCD, 0, 8'd1, 0, "R3 first open (R2 no leak)");
        run(2'd2, 3'd0, 32'h0000_0ABC, 32'h1111, 8'd1, 0, "R5 payload ctl0 R9");
        run(2'd2, 3'd1, 32'h0000_0001, 32'h2222, 8'd1, 0, "R9 ctl1");
        run(2'd2, 3'd0, 32'h0000_0000, 0, 8'd2, 0, "R7 foreign ctl");
        run(2'd2, 3'd5, 32'h0000_0000, 0, 8'd1, 0, "R8 masked ctl");
        run(2'd2, 3'd0, 32'h0000_3000, 0, 8'd1, 0, "R6 empty slot");
        run(2'd2, 3'd0, 32'h0001_0000, 0, 8'd1, 0, "R6 above range");
        run(2'd3, 3'd0, 32'h0000_0000, 0, 8'd1, 0, "R14 reserved op");
        run(2'd1, 3'd0, 32'h0000_0000, 0, 8'd2, 0, "R10 foreign close");
        run(2'd1, 3'd0, 32'h0000_4000, 0, 8'd1, 0, "R10 empty close");
        shut_ret = 32'h0000_0005;
        run(2'd1, 3'd0, 32'h0000_0123, 0, 8'd1, 0, "R11 shutdown error");
        run(2'd2, 3'd0, 32'h0000_0000, 0, 8'd1, 0, "R11 slot kept");
        shut_ret = 0;
        run(2'd1, 3'd0, 32'h0000_0000, 0, 8'd1, 0, "R11 shutdown ok");
        run(2'd2, 3'd0, 32'h0000_0000, 0, 8'd1, 0, "R11 slot freed");
        run(2'd0, 3'd0, 32'h000F_FFFF, 0, 8'd1, 3, "R13 hold open");
        run(2'd1, 3'd0, 32'h0000_0000, 0, 8'd1, 0, "R12 close no shutdown");
        for (int i = 0; i < 16; i++) run(2'd0, 3'd0, 32'h0000_1234, 0, 8'd2, 0, "R3 fill");
        run(2'd0, 3'd0, 32'h0000_0001, 0, 8'd2, 0, "R4 table full");
        for (int i = 0; i < 16; i++) run(2'd1, 3'd0, 32'(i) << 12, 0, 8'd2, 0, "R11 drain");

        for (int t = 0; t < 400; t++) begin
            int r = $urandom_range(0, 9);
            int s = $urandom_range(0, 17);
            logic [19:0] ids [5] = '{20'h0ABCD, 20'h01234, 20'hFFFFF, 20'h00001, 20'h55555};
            logic [31:0] hrs = (s > 15) ? 32'h0001_0000 : (32'(s) << 12);
            logic [31:0] rs1 = {$urandom_range(0, 4095)} & 32'hFFF | hrs;
            logic [7:0]  as = 8'($urandom_range(1, 2));
            shut_ret = ($urandom_range(0, 1) == 0) ? 32'h0 : 32'($urandom_range(1, 99));
            if (r < 3)
                run(2'd0, 3'd0, {12'($urandom), ids[$urandom_range(0, 4)]}, 0, as, 0, "R3 random open");
            else if (r < 5)
                run(2'd1, 3'd0, rs1, 0, as, 0, "R11 random close");
            else if (r < 9)
                run(2'd2, 3'($urandom_range(0, 7)), rs1, $urandom, as, $urandom_range(0, 1), "R9 random ctl");
            else
                run(2'd3, 3'd0, rs1, 0, as, 0, "R14 random reserved");
        end
        summary();
    end
endmodule